// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns the two phase signals of an incremental encoder, plus an index and a home reference, into a 32-bit signed position count. It also keeps a 16-bit revolution count, captures coherent snapshots of the position, detects a compare match, watches for the loss of motion, and reports seven sticky status flags through one registered interrupt line. All settings and readings pass through a small 16-bit register port with a 4-bit register select. Every 32-bit value is split across an upper and a lower 16-bit register.

The phase, index and home inputs are expected to be already synchronous to `clk`. The decoder can run as a 4x quadrature decoder, or as a pulse/direction counter that takes count pulses from phase A and the direction from phase B. The counting sense can be reversed. Modulo mode bounds the count between the initial value and the modulus. Index and home edges, or a software command, reload the count from the initial value.

Top module: `qdec_counter`

## Requirements
- R1: In quadrature mode (config bit 0 = 0), a change on exactly one phase moves the count by one. Taking the state as {A,B}, the sequence 00→10→11→01→00 counts up and the reverse sequence counts down. The position reads as upper half at select 10 and live lower half at select 11.
- R2: In quadrature mode, a sample in which both phases change leaves the count unchanged and sets status bit 4 (select 1).
- R3: Config bit 1 set (select 0) inverts the counting direction in both modes.
- R4: With config bit 0 set, a rising edge on phase A counts up when phase B is 0 and down when phase B is 1. Falling A edges and B changes do not count, and status bit 4 is never set.
- R5: Writing config bit 10 loads the initial value (upper half at select 4, lower half at select 5) into the count one clock later. The bit always reads back as 0.
- R6: With config bit 6 set, counting up while the count equals the modulus (selects 6/7) wraps the count to the initial value and sets status bit 5. Counting down while the count equals the initial value wraps it to the modulus and sets status bit 6.
- R7: The revolution count (select 13) moves on modulus wraps when config bit 7 is 1 (+1 on a roll-over, −1 on a roll-under). When config bit 7 is 0 it moves on each selected index edge, by +1 if the last count direction was up and by −1 otherwise.
- R8: Config bit 2 enables the index trigger and bit 3 selects its falling edge (0 = rising). The selected edge loads the initial value and sets status bit 1. The other edge has no effect.
- R9: Config bit 4 enables the home trigger and bit 5 selects its falling edge. The selected edge loads the initial value and sets status bit 0.
- R10: Status bit 3 sets while the count equals the compare value (selects 8/9), which resets to 0xFFFFFFFF. Output `matchOut` is high the cycle after an equal count. With config bit 8 set, it instead pulses for one cycle after any read of select 10, 11 or 12.
- R11: A read of select 10 captures the lower count half into select 12 and the revolution count into select 14. Both hold those values until the next such read.
- R12: With config bit 9 set, the watchdog counts clocks with no phase change. Once the count reaches the timeout at select 3, it sets status bit 2. A timeout of 0 never fires.
- R13: Status bits 6:0 are write-one-to-clear. A 0 written to a bit leaves it unchanged, and a flag event in the same cycle as its clear keeps the flag set. Status bit 7 reads the last count direction (1 = up, 0 at reset).
- R14: `irq` is high one clock after any status bit 6:0 is set while its enable bit at select 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 4 | Register select |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe, triggers snapshot and read match |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for the selected register |
| phaseA | input | 1 | Encoder phase A |
| phaseB | input | 1 | Encoder phase B |
| indexIn | input | 1 | Index reference |
| homeIn | input | 1 | Home reference |
| irq | output | 1 | Registered interrupt request |
| matchOut | output | 1 | Compare match or read pulse output |

## Verification
The bench drives wraps exactly at the modulus and at the initial value. A design with an off-by-one bound would step past the limit, or wrap one count early, and would miss the roll-over and roll-under flags. It issues a flag clear in the same cycle the compare still matches, where a clear-wins design would lose the flag, and it writes zeros to the status register, which must leave every flag as it was. It also moves the count after a snapshot, which catches a lower half taken at the wrong time, and sends index edges of the unselected polarity and a reversed-direction step, which would expose a design that reloads on both edges or ignores the reverse bit.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  localparam int NUM_FLAGS = 7;

  localparam logic [3:0] SEL_CFG      = 4'd0;
  localparam logic [3:0] SEL_STATUS   = 4'd1;
  localparam logic [3:0] SEL_IRQEN    = 4'd2;
  localparam logic [3:0] SEL_WDLIM    = 4'd3;
  localparam logic [3:0] SEL_INIT_HI  = 4'd4;
  localparam logic [3:0] SEL_INIT_LO  = 4'd5;
  localparam logic [3:0] SEL_MOD_HI   = 4'd6;
  localparam logic [3:0] SEL_MOD_LO   = 4'd7;
  localparam logic [3:0] SEL_CMP_HI   = 4'd8;
  localparam logic [3:0] SEL_CMP_LO   = 4'd9;
  localparam logic [3:0] SEL_POS_HI   = 4'd10;
  localparam logic [3:0] SEL_POS_LO   = 4'd11;
  localparam logic [3:0] SEL_HOLD_LO  = 4'd12;
  localparam logic [3:0] SEL_REV      = 4'd13;
  localparam logic [3:0] SEL_HOLD_REV = 4'd14;

  typedef struct packed {
    logic wdEn;
    logic matchOnRead;
    logic revByWrap;
    logic modEn;
    logic homeFall;
    logic homeEn;
    logic idxFall;
    logic idxEn;
    logic reverse;
    logic singlePhase;
  } cfg_t;

  typedef struct packed {
    logic loadInit;
    logic posRead;
    logic capture;
  } strobe_t;

  // field order puts rollUn at bit 6 and home at bit 0 when cast to a vector
  typedef struct packed {
    logic rollUn;
    logic rollOv;
    logic illegal;
    logic cmp;
    logic wdog;
    logic index;
    logic home;
  } events_t;

endpackage

// File: rtl/qdec_datapath.sv
module qdec_datapath
  import qdec_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfg_t             cfg,
  input  strobe_t          strb,
  input  logic [POS_W-1:0] initVal,
  input  logic [POS_W-1:0] modVal,
  input  logic [POS_W-1:0] cmpVal,
  input  logic [REG_W-1:0] wdLimit,
  input  logic             phaseA,
  input  logic             phaseB,
  input  logic             indexIn,
  input  logic             homeIn,
  output events_t          ev,
  output logic             lastDir,
  output logic [POS_W-1:0] pos,
  output logic [REG_W-1:0] rev,
  output logic [REG_W-1:0] holdLo,
  output logic [REG_W-1:0] holdRev,
  output logic             matchOut
);

  logic prevA, prevB, prevIdx, prevHome;
  logic aChg, bChg, stepEn, rawUp, stepUp, illegal;
  logic idxEv, homeEv, loadAny, wrapUp, wrapDn;
  logic [REG_W-1:0] wdCnt;
  logic wdFire;

  assign aChg = phaseA ^ prevA;
  assign bChg = phaseB ^ prevB;

  always_comb begin
    if (cfg.singlePhase) begin
      stepEn  = phaseA & ~prevA;
      rawUp   = ~phaseB;
      illegal = 1'b0;
    end else begin
      stepEn  = aChg ^ bChg;
      rawUp   = phaseA ^ prevB;
      illegal = aChg & bChg;
    end
    stepUp = rawUp ^ cfg.reverse;
  end

  assign idxEv   = cfg.idxFall  ? (prevIdx & ~indexIn)  : (~prevIdx & indexIn);
  assign homeEv  = cfg.homeFall ? (prevHome & ~homeIn)  : (~prevHome & homeIn);
  assign loadAny = strb.loadInit | (cfg.idxEn & idxEv) | (cfg.homeEn & homeEv);
  assign wrapUp  = ~loadAny & stepEn & stepUp  & cfg.modEn & (pos == modVal);
  assign wrapDn  = ~loadAny & stepEn & ~stepUp & cfg.modEn & (pos == initVal);
  assign wdFire  = cfg.wdEn & ~(aChg | bChg) & (wdLimit != '0)
                 & (wdCnt == REG_W'(wdLimit - 1'b1));

  always_comb begin
    ev         = '0;
    ev.home    = cfg.homeEn & homeEv;
    ev.index   = cfg.idxEn & idxEv;
    ev.wdog    = wdFire;
    ev.cmp     = (pos == cmpVal);
    ev.illegal = illegal;
    ev.rollOv  = wrapUp;
    ev.rollUn  = wrapDn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA    <= 1'b0;
      prevB    <= 1'b0;
      prevIdx  <= 1'b0;
      prevHome <= 1'b0;
      pos      <= '0;
      lastDir  <= 1'b0;
    end else begin
      prevA    <= phaseA;
      prevB    <= phaseB;
      prevIdx  <= indexIn;
      prevHome <= homeIn;
      if (stepEn) lastDir <= stepUp;
      if (loadAny)     pos <= initVal;
      else if (wrapUp) pos <= initVal;
      else if (wrapDn) pos <= modVal;
      else if (stepEn) pos <= stepUp ? pos + 1'b1 : pos - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rev <= '0;
    end else if (cfg.revByWrap) begin
      if (wrapUp)      rev <= rev + 1'b1;
      else if (wrapDn) rev <= rev - 1'b1;
    end else if (idxEv) begin
      rev <= lastDir ? rev + 1'b1 : rev - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdLo   <= '0;
      holdRev  <= '0;
      matchOut <= 1'b0;
    end else begin
      if (strb.capture) begin
        holdLo  <= pos[REG_W-1:0];
        holdRev <= rev;
      end
      matchOut <= cfg.matchOnRead ? strb.posRead : (pos == cmpVal);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      wdCnt <= '0;
    else if (!cfg.wdEn || aChg || bChg) wdCnt <= '0;
    else if (wdCnt != wdLimit)      wdCnt <= wdCnt + 1'b1;
  end

  // R2: an illegal sample must not move the count
  p_illegal_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (illegal && !loadAny) |=> (pos == $past(pos)));

  // R6: wraps land on the opposite bound
  p_wrap_up_r6: assert property (@(posedge clk) disable iff (!rstN)
    ev.rollOv |=> (pos == $past(initVal)));
  p_wrap_dn_r6: assert property (@(posedge clk) disable iff (!rstN)
    ev.rollUn |=> (pos == $past(modVal)));

  // R11: snapshot takes the lower half present at the read
  p_capture_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (holdLo == $past(pos[REG_W-1:0])));

endmodule

// File: rtl/qdec_ctrl.sv
module qdec_ctrl
  import qdec_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       regSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output cfg_t             cfg,
  output strobe_t          strb,
  output logic [POS_W-1:0] initVal,
  output logic [POS_W-1:0] modVal,
  output logic [POS_W-1:0] cmpVal,
  output logic [REG_W-1:0] wdLimit,
  input  events_t          ev,
  input  logic             lastDir,
  input  logic [POS_W-1:0] pos,
  input  logic [REG_W-1:0] rev,
  input  logic [REG_W-1:0] holdLo,
  input  logic [REG_W-1:0] holdRev,
  output logic             irq
);

  logic [NUM_FLAGS-1:0] flags, irqEn, evVec, clrVec;
  logic loadCmd;

  assign evVec  = NUM_FLAGS'(ev);
  assign clrVec = (wrEn && regSel == SEL_STATUS) ? wrData[NUM_FLAGS-1:0] : '0;

  always_comb begin
    strb          = '0;
    strb.loadInit = loadCmd;
    strb.posRead  = rdEn && (regSel == SEL_POS_HI || regSel == SEL_POS_LO
                             || regSel == SEL_HOLD_LO);
    strb.capture  = rdEn && (regSel == SEL_POS_HI);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= '0;
      loadCmd <= 1'b0;
      irqEn   <= '0;
      wdLimit <= '0;
      initVal <= '0;
      modVal  <= '0;
      cmpVal  <= '1;
    end else begin
      loadCmd <= wrEn && (regSel == SEL_CFG) && wrData[10];
      if (wrEn) begin
        case (regSel)
          SEL_CFG:     cfg <= cfg_t'(wrData[9:0]);
          SEL_IRQEN:   irqEn <= wrData[NUM_FLAGS-1:0];
          SEL_WDLIM:   wdLimit <= wrData;
          SEL_INIT_HI: initVal[POS_W-1:REG_W] <= wrData;
          SEL_INIT_LO: initVal[REG_W-1:0] <= wrData;
          SEL_MOD_HI:  modVal[POS_W-1:REG_W] <= wrData;
          SEL_MOD_LO:  modVal[REG_W-1:0] <= wrData;
          SEL_CMP_HI:  cmpVal[POS_W-1:REG_W] <= wrData;
          SEL_CMP_LO:  cmpVal[REG_W-1:0] <= wrData;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~clrVec) | evVec;
      irq   <= |(flags & irqEn);
    end
  end

  always_comb begin
    case (regSel)
      SEL_CFG:      rdData = REG_W'(cfg);
      SEL_STATUS:   rdData = REG_W'({lastDir, flags});
      SEL_IRQEN:    rdData = REG_W'(irqEn);
      SEL_WDLIM:    rdData = wdLimit;
      SEL_INIT_HI:  rdData = initVal[POS_W-1:REG_W];
      SEL_INIT_LO:  rdData = initVal[REG_W-1:0];
      SEL_MOD_HI:   rdData = modVal[POS_W-1:REG_W];
      SEL_MOD_LO:   rdData = modVal[REG_W-1:0];
      SEL_CMP_HI:   rdData = cmpVal[POS_W-1:REG_W];
      SEL_CMP_LO:   rdData = cmpVal[REG_W-1:0];
      SEL_POS_HI:   rdData = pos[POS_W-1:REG_W];
      SEL_POS_LO:   rdData = pos[REG_W-1:0];
      SEL_HOLD_LO:  rdData = holdLo;
      SEL_REV:      rdData = rev;
      SEL_HOLD_REV: rdData = holdRev;
      default:      rdData = '0;
    endcase
  end

  // R13: an event wins over a clear in the same cycle
  p_set_wins_r13: assert property (@(posedge clk) disable iff (!rstN)
    (evVec != '0) |=> ((flags & $past(evVec)) == $past(evVec)));

  // R14: an enabled pending flag raises the interrupt next cycle
  p_irq_follows_r14: assert property (@(posedge clk) disable iff (!rstN)
    ((flags & irqEn) != '0) |=> irq);

  // R5: the software load command lasts a single cycle
  p_load_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    loadCmd |=> !loadCmd);

endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
  import qdec_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       regSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             phaseA,
  input  logic             phaseB,
  input  logic             indexIn,
  input  logic             homeIn,
  output logic             irq,
  output logic             matchOut
);

  localparam int POS_W = 2 * REG_W;

  cfg_t             cfg;
  strobe_t          strb;
  events_t          ev;
  logic [POS_W-1:0] initVal, modVal, cmpVal, pos;
  logic [REG_W-1:0] wdLimit, rev, holdLo, holdRev;
  logic             lastDir;

  qdec_ctrl #(.REG_W(REG_W), .POS_W(POS_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .cfg(cfg), .strb(strb),
    .initVal(initVal), .modVal(modVal), .cmpVal(cmpVal), .wdLimit(wdLimit),
    .ev(ev), .lastDir(lastDir), .pos(pos), .rev(rev), .holdLo(holdLo),
    .holdRev(holdRev), .irq(irq)
  );

  qdec_datapath #(.REG_W(REG_W), .POS_W(POS_W)) uDp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb), .initVal(initVal),
    .modVal(modVal), .cmpVal(cmpVal), .wdLimit(wdLimit), .phaseA(phaseA),
    .phaseB(phaseB), .indexIn(indexIn), .homeIn(homeIn), .ev(ev),
    .lastDir(lastDir), .pos(pos), .rev(rev), .holdLo(holdLo),
    .holdRev(holdRev), .matchOut(matchOut)
  );

endmodule

// File: tb/qdec_counter_test.sv
module qdec_counter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regSel = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        phaseA = 1'b0, phaseB = 1'b0, indexIn = 1'b0, homeIn = 1'b0;
  logic        irq, matchOut;

  int applied = 0;
  int miscompares = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  qdec_counter uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .phaseA(phaseA), .phaseB(phaseB),
    .indexIn(indexIn), .homeIn(homeIn), .irq(irq), .matchOut(matchOut)
  );

  // {A,B, expected position} after each quadrature step from state 00, count 0
  localparam logic [33:0] VEC [0:11] = '{
    {2'b10, 32'd1}, {2'b11, 32'd2}, {2'b01, 32'd3}, {2'b00, 32'd4},
    {2'b01, 32'd3}, {2'b11, 32'd2}, {2'b10, 32'd1}, {2'b00, 32'd0},
    {2'b01, 32'hFFFF_FFFF}, {2'b00, 32'd0},
    {2'b11, 32'd0}, {2'b00, 32'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [15:0] d);
    @(negedge clk);
    regSel = s; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [15:0] v);
    @(negedge clk);
    regSel = s; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic readPos(output logic [31:0] p);
    logic [15:0] hi, lo;
    rd(4'd10, hi);
    rd(4'd12, lo);
    p = {hi, lo};
  endtask

  task automatic step(input logic a, input logic b);
    @(negedge clk);
    phaseA = a; phaseB = b;
    @(negedge clk);
  endtask

  task automatic edgeIdx(input logic v);
    @(negedge clk); indexIn = v; @(negedge clk);
  endtask

  task automatic edgeHome(input logic v);
    @(negedge clk); homeIn = v; @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [31:0] p;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    rd(4'd1, v);  chk("R13 reset status", 32'(v), 32'h0000);
    rd(4'd8, v);  chk("R10 reset compare hi", 32'(v), 32'hFFFF);
    rd(4'd9, v);  chk("R10 reset compare lo", 32'(v), 32'hFFFF);
    readPos(p);   chk("R1 reset position", p, 32'd0);
    chk("R14 reset irq", 32'(irq), 32'd0);

    // R1 R2 vector table
    for (int i = 0; i < 12; i++) begin
      step(VEC[i][33], VEC[i][32]);
      readPos(p);
      chk(i < 10 ? "R1 quadrature step" : "R2 illegal step", p, VEC[i][31:0]);
    end
    rd(4'd1, v);  chk("R2 R10 R13 status after table", 32'(v), 32'h0098);

    // R13 write-one-to-clear
    wr(4'd1, 16'h0000);
    rd(4'd1, v);  chk("R13 zero write keeps flags", 32'(v), 32'h0098);
    wr(4'd1, 16'h0018);
    rd(4'd1, v);  chk("R13 clear selected flags", 32'(v), 32'h0080);

    // R3 reverse
    wr(4'd0, 16'h0002);
    step(1'b1, 1'b0);
    readPos(p);   chk("R3 reversed up-step counts down", p, 32'hFFFF_FFFF);
    rd(4'd1, v);  chk("R3 R13 direction bit down", 32'(v), 32'h0008);
    step(1'b0, 1'b0);
    readPos(p);   chk("R3 reversed down-step counts up", p, 32'd0);
    wr(4'd1, 16'h007F);

    // R4 single phase
    wr(4'd0, 16'h0001);
    step(1'b1, 1'b0); readPos(p); chk("R4 A rise B low up", p, 32'd1);
    step(1'b0, 1'b0); readPos(p); chk("R4 A fall ignored", p, 32'd1);
    step(1'b0, 1'b1); readPos(p); chk("R4 B change ignored", p, 32'd1);
    step(1'b1, 1'b1); readPos(p); chk("R4 A rise B high down", p, 32'd0);
    step(1'b0, 1'b0);
    rd(4'd1, v);  chk("R4 no illegal flag", 32'(v & 16'h0010), 32'd0);

    // R5 software load
    wr(4'd4, 16'h0001); wr(4'd5, 16'h0005);
    wr(4'd0, 16'h0400);
    readPos(p);   chk("R5 software load", p, 32'h0001_0005);
    rd(4'd0, v);  chk("R5 command bit reads zero", 32'(v), 32'h0000);

    // R6 R7 modulo with wrap-driven revolution count
    wr(4'd4, 16'h0000); wr(4'd5, 16'h0002);
    wr(4'd6, 16'h0000); wr(4'd7, 16'h0004);
    wr(4'd0, 16'h04C0);
    readPos(p);   chk("R5 load initial two", p, 32'd2);
    step(1'b1, 1'b0); step(1'b1, 1'b1);
    readPos(p);   chk("R6 count to modulus", p, 32'd4);
    step(1'b0, 1'b1);
    readPos(p);   chk("R6 roll-over to initial", p, 32'd2);
    rd(4'd13, v); chk("R7 revolution up on roll-over", 32'(v), 32'd1);
    step(1'b1, 1'b1);
    readPos(p);   chk("R6 roll-under to modulus", p, 32'd4);
    rd(4'd13, v); chk("R7 revolution down on roll-under", 32'(v), 32'd0);
    rd(4'd1, v);  chk("R6 roll flags", 32'(v), 32'h0060);
    wr(4'd1, 16'h007F);

    // R11 coherent snapshot
    readPos(p);   chk("R11 snapshot value", p, 32'd4);
    step(1'b0, 1'b1);
    rd(4'd12, v); chk("R11 hold low stays", 32'(v), 32'd4);
    rd(4'd14, v); chk("R11 hold revolution stays", 32'(v), 32'd0);
    rd(4'd11, v); chk("R11 live low moved", 32'(v), 32'd2);
    rd(4'd13, v); chk("R7 live revolution moved", 32'(v), 32'd1);
    wr(4'd1, 16'h007F);

    // R8 index trigger, R7 index-driven revolution count
    wr(4'd5, 16'h0100);
    wr(4'd0, 16'h0004);
    edgeIdx(1'b1);
    readPos(p);   chk("R8 rising index loads", p, 32'h100);
    rd(4'd1, v);  chk("R8 index flag", 32'(v & 16'h0002), 32'h0002);
    edgeIdx(1'b0);
    wr(4'd0, 16'h000C);
    step(1'b0, 1'b0);
    edgeIdx(1'b1);
    readPos(p);   chk("R8 rise ignored in falling mode", p, 32'h101);
    edgeIdx(1'b0);
    readPos(p);   chk("R8 falling index loads", p, 32'h100);
    rd(4'd13, v); chk("R7 revolution counts index edges", 32'(v), 32'd3);
    wr(4'd1, 16'h007F);

    // R9 home trigger, falling edge
    wr(4'd0, 16'h0030);
    step(1'b0, 1'b1);
    edgeHome(1'b1);
    readPos(p);   chk("R9 home rise ignored", p, 32'hFF);
    rd(4'd1, v);  chk("R9 no flag on wrong edge", 32'(v & 16'h0001), 32'd0);
    edgeHome(1'b0);
    readPos(p);   chk("R9 home fall loads", p, 32'h100);
    rd(4'd1, v);  chk("R9 home flag", 32'(v & 16'h0001), 32'h0001);
    wr(4'd1, 16'h007F);

    // R10 compare, R13 set wins, R14 interrupt
    wr(4'd0, 16'h0000);
    wr(4'd2, 16'h0008);
    wr(4'd8, 16'h0000); wr(4'd9, 16'h0102);
    step(1'b0, 1'b0); step(1'b1, 1'b0);
    rd(4'd1, v);  chk("R10 compare flag", 32'(v & 16'h0008), 32'h0008);
    chk("R14 irq on enabled flag", 32'(irq), 32'd1);
    chk("R10 match output level", 32'(matchOut), 32'd1);
    wr(4'd1, 16'h0008);
    rd(4'd1, v);  chk("R13 set wins over clear", 32'(v & 16'h0008), 32'h0008);
    step(1'b1, 1'b1);
    wr(4'd1, 16'h0008);
    rd(4'd1, v);  chk("R13 clear after match ends", 32'(v), 32'h0080);
    chk("R14 irq drops", 32'(irq), 32'd0);

    // R10 match on read
    wr(4'd0, 16'h0100);
    @(negedge clk);
    chk("R10 read-mode idle", 32'(matchOut), 32'd0);
    regSel = 4'd11; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    chk("R10 read pulse", 32'(matchOut), 32'd1);
    @(negedge clk);
    chk("R10 read pulse ends", 32'(matchOut), 32'd0);

    // R12 watchdog
    wr(4'd3, 16'd5);
    wr(4'd0, 16'h0200);
    rd(4'd1, v);  chk("R12 no timeout yet", 32'(v & 16'h0004), 32'd0);
    repeat (10) @(negedge clk);
    rd(4'd1, v);  chk("R12 timeout flag", 32'(v & 16'h0004), 32'h0004);
    chk("R14 masked flag keeps irq low", 32'(irq), 32'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule